// File: doc/BRIEF.md
# Prefixed Accumulator Logic Execute Unit

This block executes three instructions of a 16-bit accumulator machine: a logical OR of the accumulator with a source, two's-complement negation of the accumulator, and forcing one bit of an addressed module register to 1. It holds the working accumulator, a one-shot prefix byte and the sign and zero flags. Instruction words arrive with a valid strobe. The block also drives a register-read address and takes the data back in the same cycle.

An OR can take an 8-bit immediate or a 16-bit register source. For an immediate, a pending prefix byte fills the upper half of the operand. The prefix is loaded by its own strobe and is dropped once the next instruction executes. The bit-set instruction is a read-modify-write: the register is read in the issue cycle, and a one-cycle write pulse carries the modified value back. The processor status register is written through this same path, so its carry and extension bits change with it.

Top module: `acc_logic_exec`

## Requirements
- R1: After reset, `acc` is 0000h, `flag_s` is 0, `flag_z` is 1, and `illegal` and `wr_en` are 0.
- R2: A valid word of the form 1010_1010_ssss_ssss is a register OR. While the word is presented, `rd_addr` equals the low byte. On the next clock edge, `acc` becomes `acc | rd_data`.
- R3: A valid word of the form 0010_1010_iiii_iiii is an immediate OR. With no pending prefix, the operand is {00h, iiii_iiii}.
- R4: A `pfx_valid` pulse stores `pfx_byte` as pending. The pending byte survives idle cycles. The next valid instruction uses it as the upper half of an immediate operand and then clears it, so accumulator 2345h, prefix 11h and OR #33h give 3377h.
- R5: A register OR whose source byte is 08h (the accumulator itself) produces a one-cycle `illegal` pulse on the next edge. It leaves `acc` and the flags unchanged, yet still consumes the pending prefix.
- R6: The word 8A9Ah sets `acc` to `~acc + 1`. FEEDh becomes 0113h.
- R7: After an OR or a negate, `flag_s` equals bit 15 of the new `acc` and `flag_z` is 1 exactly when the new `acc` is zero. Other instructions leave both flags unchanged.
- R8: A valid word 1ddd_dddd_1bbb_0111 is a bit-set. While it is presented, `rd_addr` is {0, ddd_dddd}. On the next edge, `wr_en` pulses with `wr_addr` = {0, ddd_dddd} and `wr_data` = `rd_data` with bit bbb set. Successive sets of bits 1 and 7 on 0000h give 0002h, then 0082h.
- R9: The bit-set module is d[3:0]. Modules 0 to 5 and module 8 are accepted. Any other module raises `illegal` and produces no write.
- R10: A valid word matching none of the three forms raises `illegal` and changes neither `acc` nor the flags.
- R11: While `instr_valid` is low, the word is ignored: `acc` and the flags hold, and `wr_en` and `illegal` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction strobe |
| instr_word | input | 16 | Instruction word |
| pfx_valid | input | 1 | Prefix load strobe |
| pfx_byte | input | 8 | Prefix byte |
| rd_addr | output | 8 | Register read address (combinational) |
| rd_data | input | 16 | Register read data, same cycle |
| wr_en | output | 1 | Bit-set write pulse |
| wr_addr | output | 8 | Bit-set write address |
| wr_data | output | 16 | Bit-set write value |
| illegal | output | 1 | Illegal-operation pulse |
| acc | output | 16 | Accumulator |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |

## Verification
An operand formed wrongly or a prefix left pending shows up in `acc` one edge after the instruction that uses it. A stale prefix only shows when a second immediate OR follows, so the bench issues immediates back to back. A wrong module decode or bit mask shows on `wr_en`/`wr_data` one edge after issue. A flag that drifts from the accumulator is visible at once, because `flag_s` and `flag_z` must always agree with `acc`.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;
   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_OR   = 2'd1,
      OP_NEG  = 2'd2,
      OP_BSET = 2'd3
   } op_e;

   typedef struct packed {
      op_e        op;
      logic       bad;
      logic       src_reg;
      logic [7:0] sel;
      logic [2:0] bit_idx;
   } dec_t;

   localparam logic [6:0]  OR_HI_PATTERN = 7'h2A;
   localparam logic [15:0] NEG_WORD      = 16'h8A9A;
   localparam logic [3:0]  BSET_LOW_NIB  = 4'h7;
endpackage

// File: rtl/acc_exec_decode.sv
module acc_exec_decode
   import acc_exec_pkg::*;
#(
   parameter int         MOD_COUNT   = 16,
   parameter int         SYS_MODULE  = 8,
   parameter int         PERIPH_LAST = 5,
   parameter logic [7:0] ACC_SEL     = 8'h08
) (
   input  logic [15:0] word,
   output dec_t        dec
);
   localparam int MOD_W = $clog2(MOD_COUNT);

   generate
      if (SYS_MODULE >= MOD_COUNT || PERIPH_LAST >= MOD_COUNT) begin : g_bad_map
         $error("module map parameter out of range");
      end
   endgenerate

   logic [MOD_COUNT-1:0] mod_ok;

   generate
      for (genvar m = 0; m < MOD_COUNT; m++) begin : g_mod
         assign mod_ok[m] = (m == SYS_MODULE) || (m <= PERIPH_LAST);
      end
   endgenerate

   logic is_or, is_neg, is_bset;
   logic [MOD_W-1:0] dst_mod;

   assign is_or   = (word[14:8] == OR_HI_PATTERN);
   assign is_neg  = (word == NEG_WORD);
   assign is_bset = word[15] && word[7] && (word[3:0] == BSET_LOW_NIB);
   assign dst_mod = word[8 +: MOD_W];

   always_comb begin
      dec         = '0;
      dec.op      = OP_NONE;
      dec.src_reg = word[15];
      dec.bit_idx = word[6:4];
      dec.sel     = word[7:0];
      if (is_or) begin
         if (word[15] && (word[7:0] == ACC_SEL)) dec.bad = 1'b1;
         else                                     dec.op  = OP_OR;
      end else if (is_neg) begin
         dec.op = OP_NEG;
      end else if (is_bset) begin
         dec.sel = {1'b0, word[14:8]};
         if (mod_ok[dst_mod]) dec.op  = OP_BSET;
         else                 dec.bad = 1'b1;
      end else begin
         dec.bad = 1'b1;
      end
   end
endmodule

// File: rtl/acc_exec_prefix.sv
module acc_exec_prefix #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_byte,
   input  logic              consume,
   output logic [BYTE_W-1:0] hi_byte
);
   logic              pend_q;
   logic [BYTE_W-1:0] byte_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         byte_q <= '0;
      end else if (load) begin
         pend_q <= 1'b1;
         byte_q <= load_byte;
      end else if (consume) begin
         pend_q <= 1'b0;
         byte_q <= '0;
      end
   end

   assign hi_byte = pend_q ? byte_q : '0;
endmodule

// File: rtl/acc_exec_alu.sv
module acc_exec_alu
   import acc_exec_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int IMM_W  = 8
) (
   input  dec_t              dec,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] rd_val,
   input  logic [IMM_W-1:0]  hi_byte,
   output logic [DATA_W-1:0] acc_res,
   output logic [DATA_W-1:0] bset_res
);
   localparam int BIT_SPAN = 1 << $bits(dec.bit_idx);

   logic [DATA_W-1:0] operand;
   logic [DATA_W-1:0] mask;

   assign operand = dec.src_reg ? rd_val
                                : {{(DATA_W-2*IMM_W){1'b0}}, hi_byte, dec.sel};

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_mask
         if (i < BIT_SPAN) begin : g_live
            assign mask[i] = (dec.bit_idx == i[2:0]);
         end else begin : g_dead
            assign mask[i] = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      case (dec.op)
         OP_OR:   acc_res = acc_in | operand;
         OP_NEG:  acc_res = ~acc_in + 1'b1;
         default: acc_res = acc_in;
      endcase
   end

   assign bset_res = rd_val | mask;
endmodule

// File: rtl/acc_logic_exec.sv
module acc_logic_exec
   import acc_exec_pkg::*;
#(
   parameter int         DATA_W      = 16,
   parameter int         ADDR_W      = 8,
   parameter int         SYS_MODULE  = 8,
   parameter int         PERIPH_LAST = 5,
   parameter logic [7:0] ACC_SEL     = 8'h08
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [15:0]       instr_word,
   input  logic              pfx_valid,
   input  logic [7:0]        pfx_byte,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              illegal,
   output logic [DATA_W-1:0] acc,
   output logic              flag_s,
   output logic              flag_z
);
   localparam int BYTE_W = DATA_W / 2;

   generate
      if (DATA_W != 16 || ADDR_W != 8) begin : g_bad_width
         $error("execute unit supports 16-bit data and 8-bit addresses only");
      end
   endgenerate

   dec_t              dec;
   logic [BYTE_W-1:0] hi_byte;
   logic [DATA_W-1:0] acc_res, bset_res;
   logic              upd_acc;

   acc_exec_decode #(
      .MOD_COUNT  (16),
      .SYS_MODULE (SYS_MODULE),
      .PERIPH_LAST(PERIPH_LAST),
      .ACC_SEL    (ACC_SEL)
   ) u_dec (
      .word(instr_word),
      .dec (dec)
   );

   acc_exec_prefix #(.BYTE_W(BYTE_W)) u_pfx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (pfx_valid),
      .load_byte(pfx_byte),
      .consume  (instr_valid),
      .hi_byte  (hi_byte)
   );

   acc_exec_alu #(.DATA_W(DATA_W), .IMM_W(BYTE_W)) u_alu (
      .dec     (dec),
      .acc_in  (acc),
      .rd_val  (rd_data),
      .hi_byte (hi_byte),
      .acc_res (acc_res),
      .bset_res(bset_res)
   );

   assign rd_addr = dec.sel;
   assign upd_acc = instr_valid && (dec.op == OP_OR || dec.op == OP_NEG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc    <= '0;
         flag_s <= 1'b0;
         flag_z <= 1'b1;
      end else if (upd_acc) begin
         acc    <= acc_res;
         flag_s <= acc_res[DATA_W-1];
         flag_z <= (acc_res == '0);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         illegal <= 1'b0;
      end else begin
         wr_en   <= instr_valid && (dec.op == OP_BSET);
         illegal <= instr_valid && dec.bad;
         if (instr_valid && dec.op == OP_BSET) begin
            wr_addr <= rd_addr;
            wr_data <= bset_res;
         end
      end
   end
endmodule

// File: rtl/acc_logic_exec_chk.sv
module acc_logic_exec_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        instr_valid,
   input logic [15:0] instr_word,
   input logic [7:0]  rd_addr,
   input logic [15:0] rd_data,
   input logic        wr_en,
   input logic [7:0]  wr_addr,
   input logic [15:0] wr_data,
   input logic        illegal,
   input logic [15:0] acc,
   input logic        flag_s,
   input logic        flag_z
);
   AST_SIGN_TRACKS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      flag_s == acc[15]);                                            // R7
   AST_ZERO_TRACKS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      flag_z == (acc == 16'h0000));                                  // R7
   AST_WRITE_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(instr_valid));                                 // R8
   AST_WRITE_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ((wr_data | $past(rd_data)) == wr_data));            // R8
   AST_WRITE_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (((wr_data >> $past(instr_word[6:4])) & 16'h1) == 16'h1)); // R8
   AST_WRITE_MODULE_OK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_addr[3:0] <= 4'd5 || wr_addr[3:0] == 4'd8));     // R9
   AST_ILLEGAL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!wr_en && $stable(acc)));                         // R10
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |=> ($stable(acc) && !wr_en && !illegal));        // R11
endmodule

bind acc_logic_exec acc_logic_exec_chk u_chk (.*);

// File: tb/acc_logic_exec_tb.sv
module acc_logic_exec_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [15:0] instr_word = 16'h0000;
   logic        pfx_valid = 1'b0;
   logic [7:0]  pfx_byte = 8'h00;
   logic [7:0]  rd_addr;
   logic [15:0] rd_data;
   logic        wr_en;
   logic [7:0]  wr_addr;
   logic [15:0] wr_data;
   logic        illegal;
   logic [15:0] acc;
   logic        flag_s, flag_z;

   logic [15:0] regs [256];
   logic [7:0]  seen_rd;
   int          checks = 0;
   int          errors = 0;

   always #2 clk = ~clk;

   acc_logic_exec u_dut (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
      .pfx_valid(pfx_valid), .pfx_byte(pfx_byte), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .illegal(illegal),
      .acc(acc), .flag_s(flag_s), .flag_z(flag_z)
   );

   assign rd_data = regs[rd_addr];
   always @(posedge clk) if (wr_en) regs[wr_addr] <= wr_data;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      instr_valid = 1'b0;
      pfx_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic exec(input logic [15:0] w);
      @(negedge clk);
      instr_valid = 1'b1;
      instr_word = w;
      #1 seen_rd = rd_addr;
      @(negedge clk);
      instr_valid = 1'b0;
   endtask

   task automatic prefix(input logic [7:0] b);
      @(negedge clk);
      pfx_valid = 1'b1;
      pfx_byte = b;
      @(negedge clk);
      pfx_valid = 1'b0;
   endtask

   task automatic load_acc(input logic [15:0] v);
      do_reset();
      prefix(v[15:8]);
      exec({8'h2A, v[7:0]});
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 acc", acc, 16'h0000);
      chk("R1 s/z", {flag_s, flag_z}, 2'b01);
      chk("R1 illegal/wr_en", {illegal, wr_en}, 2'b00);
   endtask

   task automatic t_or_imm();
      do_reset();
      exec(16'h2A80);
      chk("R3 acc", acc, 16'h0080);
      chk("R7 s/z after OR", {flag_s, flag_z}, 2'b00);
   endtask

   task automatic t_or_reg();
      load_acc(16'h2345);
      chk("R4 load", acc, 16'h2345);
      regs[8'h13] = 16'h0F0F;
      exec(16'hAA13);
      chk("R2 rd_addr", seen_rd, 8'h13);
      chk("R2 acc", acc, 16'h2F4F);
   endtask

   task automatic t_prefix();
      load_acc(16'h2345);
      prefix(8'h11);
      exec(16'h2A33);
      chk("R4 merged", acc, 16'h3377);
      exec(16'h2A80);
      chk("R4 cleared", acc, 16'h33F7);
      do_reset();
      prefix(8'h80);
      repeat (3) @(negedge clk);
      exec(16'h2A01);
      chk("R4 held over idle", acc, 16'h8001);
      chk("R7 sign", {flag_s, flag_z}, 2'b10);
   endtask

   task automatic t_acc_src();
      load_acc(16'h2345);
      prefix(8'h55);
      exec(16'hAA08);
      chk("R5 illegal", illegal, 1'b1);
      chk("R5 acc held", acc, 16'h2345);
      exec(16'h2A00);
      chk("R5 prefix consumed", acc, 16'h2345);
      chk("R5 pulse ends", illegal, 1'b0);
   endtask

   task automatic t_neg();
      load_acc(16'hFEED);
      exec(16'h8A9A);
      chk("R6 negate", acc, 16'h0113);
      chk("R6 s/z", {flag_s, flag_z}, 2'b00);
      load_acc(16'h0001);
      exec(16'h8A9A);
      chk("R7 neg sign", {acc, flag_s, flag_z}, {16'hFFFF, 2'b10});
      do_reset();
      exec(16'h8A9A);
      chk("R7 neg zero", {acc, flag_s, flag_z}, {16'h0000, 2'b01});
   endtask

   task automatic t_bitset();
      load_acc(16'h8000);
      regs[8'h20] = 16'h0000;
      exec(16'hA097);
      chk("R8 rd_addr", seen_rd, 8'h20);
      chk("R8 write", {wr_en, wr_addr, wr_data}, {1'b1, 8'h20, 16'h0002});
      exec(16'hA0F7);
      chk("R8 second bit", {wr_en, wr_data}, {1'b1, 16'h0082});
      chk("R7 flags kept on bit-set", {acc, flag_s, flag_z}, {16'h8000, 2'b10});
      regs[8'h48] = 16'h0100;
      exec(16'hC8B7);
      chk("R9 module 8", {wr_en, wr_addr, wr_data}, {1'b1, 8'h48, 16'h0108});
      exec(16'h9587);
      chk("R9 module 5", {wr_en, wr_addr}, {1'b1, 8'h15});
      exec(16'h9687);
      chk("R9 module 6 rejected", {wr_en, illegal}, 2'b01);
      exec(16'hFF87);
      chk("R9 module 15 rejected", {wr_en, illegal}, 2'b01);
   endtask

   task automatic t_unknown();
      load_acc(16'h1234);
      exec(16'h1234);
      chk("R10 illegal", illegal, 1'b1);
      chk("R10 state", {acc, flag_s, flag_z}, {16'h1234, 2'b00});
   endtask

   task automatic t_idle();
      load_acc(16'h00F0);
      @(negedge clk);
      instr_word = 16'h8A9A;
      repeat (3) @(negedge clk);
      chk("R11 acc", acc, 16'h00F0);
      chk("R11 pulses", {wr_en, illegal}, 2'b00);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) regs[i] = 16'h0000;
      t_reset();
      t_or_imm();
      t_or_reg();
      t_prefix();
      t_acc_src();
      t_neg();
      t_bitset();
      t_unknown();
      t_idle();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule